// File: doc/BRIEF.md
# Pipelined Radix-4 Booth Multiplier with Carry-Save Output

This block multiplies an unsigned 54-bit multiplicand by an unsigned 53-bit multiplier. It is sized for the significand product of a double-precision multiply. Radix-4 Booth recoding turns the multiplier into 27 signed digits. Each digit selects 0, ±1 or ±2 times the multiplicand, weighted by 4^i. Layers of 3-to-2 carry-save adders then compress these 27 partial products to two vectors. The compression runs over five registered stages, and the vector count after the stages is 18, 12, 6, 4 and 2.

The result leaves the block in redundant form, as a sum vector and a carry vector. The product is their sum modulo 2^107. The final carry-propagate adder, rounding and normalisation belong to the logic that follows. A valid strobe travels alongside the data. The pipeline takes a new operand pair on every clock and has a fixed latency of five clocks.

Top module: `booth_csa_mult`

## Requirements
- R1: For every accepted operand pair, (sum_vec + carry_vec) mod 2^107 equals mcand × mplier, both operands treated as unsigned.
- R2: If in_valid is high in clock cycle c, out_valid is high in cycle c+5 and carries that pair's result. If in_valid is low in cycle c, out_valid is low in cycle c+5.
- R3: Operand pairs presented on consecutive cycles produce results on consecutive cycles, in the order they were presented, with no stall.
- R4: A synchronous, active-high rst drops out_valid in the cycle after the reset edge and discards every pair still in flight. While rst is high, in_valid is not accepted.
- R5: While in_valid is low, the values on mcand and mplier produce no valid output.
- R6: The largest operands (all ones on both buses) give the exact product. The top Booth digit is never negative because the multiplier is zero-extended.
- R7: Multipliers whose recoding gives many negative digits (−1 and −2, from groups 100, 101 and 110) give the exact product.
- R8: A zero multiplicand gives a sum and carry pair that adds to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the valid pipeline |
| in_valid | input | 1 | Operand pair on mcand and mplier is accepted this cycle |
| mcand | input | MCAND_W (54) | Unsigned multiplicand |
| mplier | input | MPLIER_W (53) | Unsigned multiplier, the operand that is Booth recoded |
| out_valid | output | 1 | sum_vec and carry_vec hold a result |
| sum_vec | output | MCAND_W+MPLIER_W (107) | Sum half of the carry-save product |
| carry_vec | output | MCAND_W+MPLIER_W (107) | Carry half of the carry-save product |

## Verification
The bench builds the block with its default widths, 54 by 53 bits. These give the full 27-digit recoding and the complete 27-18-12-6-4-2 compression schedule. They also reach the 107-bit wrap of the sign-extension ones and the top Booth group, which is fed only by zero extension. With these widths the bench can drive operands that set every recoding group, including the all-ones pair and patterns that give long runs of −1 and −2 digits. It can also drive back-to-back streams with bubbles and a reset in the middle of a stream.

// File: rtl/booth_csa_mult.sv
module booth_csa_mult #(
  parameter int MCAND_W  = 54,
  parameter int MPLIER_W = 53
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [MCAND_W-1:0]          mcand,
  input  logic [MPLIER_W-1:0]         mplier,
  output logic                        out_valid,
  output logic [MCAND_W+MPLIER_W-1:0] sum_vec,
  output logic [MCAND_W+MPLIER_W-1:0] carry_vec
);
  localparam int PROD_W = MCAND_W + MPLIER_W;
  localparam int NPP    = (MPLIER_W + 2) / 2;
  localparam int BX_W   = 2 * NPP + 1;
  localparam int N1 = NPP - NPP / 3;
  localparam int N2 = N1 - N1 / 3;
  localparam int N3 = N2 - N2 / 3;
  localparam int N4 = N3 - N3 / 3;
  localparam int N5 = N4 - N4 / 3;
  localparam int N6 = N5 - N5 / 3;

  typedef logic [PROD_W-1:0] vec_t [NPP];

  function automatic vec_t csa_layer(vec_t v, int n);
    vec_t r;
    logic [PROD_W-1:0] a, b, c;
    for (int k = 0; k < NPP; k++) r[k] = '0;
    for (int k = 0; k < n / 3; k++) begin
      a = v[3*k];
      b = v[3*k+1];
      c = v[3*k+2];
      r[2*k]   = a ^ b ^ c;
      r[2*k+1] = ((a & b) | (a & c) | (b & c)) << 1;
    end
    for (int k = 3 * (n / 3); k < n; k++) r[k - (n / 3)] = v[k];
    return r;
  endfunction

  logic [BX_W-1:0]   bx;
  logic [PROD_W-1:0] ext;
  logic [NPP-1:0]    neg;
  vec_t              pp;

  assign bx  = {{(BX_W-MPLIER_W-1){1'b0}}, mplier, 1'b0};
  assign ext = PROD_W'(mcand);

  for (genvar i = 0; i < NPP; i++) begin : g_pp
    logic [2:0]        grp;
    logic              one, two;
    logic [PROD_W-1:0] mul, sel;
    assign grp    = bx[2*i+2 -: 3];
    assign one    = grp[1] ^ grp[0];
    assign two    = (grp == 3'b011) | (grp == 3'b100);
    assign neg[i] = grp[2] & ~(grp[1] & grp[0]);
    assign mul    = two ? (ext << 1) : (one ? ext : '0);
    assign sel    = (neg[i] ? ~mul : mul) << (2 * i);
    if (i == 0) begin : g_first
      assign pp[i] = sel;
    end else begin : g_rest
      assign pp[i] = sel | (PROD_W'(neg[i-1]) << (2 * i - 2));
    end
  end

  vec_t l1, l2, l3, l4, l5, l6, l7;
  vec_t s1, s2, s3, s4, s5;
  logic [4:0] vld;

  always_comb begin
    l1 = csa_layer(pp, NPP);
    l2 = csa_layer(s1, N1);
    l3 = csa_layer(s2, N2);
    l4 = csa_layer(l3, N3);
    l5 = csa_layer(s3, N4);
    l6 = csa_layer(s4, N5);
    l7 = csa_layer(l6, N6);
  end

  always_ff @(posedge clk) begin
    s1 <= l1;
    s2 <= l2;
    s3 <= l4;
    s4 <= l5;
    s5 <= l7;
    if (rst) vld <= '0;
    else     vld <= {vld[3:0], in_valid};
  end

  assign out_valid = vld[4];
  assign sum_vec   = s5[0];
  assign carry_vec = s5[1];
endmodule

// File: rtl/booth_csa_mult_chk.sv
module booth_csa_mult_chk #(
  parameter int MCAND_W  = 54,
  parameter int MPLIER_W = 53
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic [MCAND_W-1:0]          mcand,
  input logic [MPLIER_W-1:0]         mplier,
  input logic                        out_valid,
  input logic [MCAND_W+MPLIER_W-1:0] sum_vec,
  input logic [MCAND_W+MPLIER_W-1:0] carry_vec
);
  localparam int PROD_W = MCAND_W + MPLIER_W;

  logic [4:0]        vp;
  logic [PROD_W-1:0] pq [5];

  always_ff @(posedge clk) begin
    if (rst) vp <= '0;
    else     vp <= {vp[3:0], in_valid};
    pq[0] <= PROD_W'(mcand) * PROD_W'(mplier);
    for (int k = 1; k < 5; k++) pq[k] <= pq[k-1];
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == vp[4]); // R2
  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (PROD_W'(sum_vec + carry_vec) == pq[4])); // R1
  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid); // R4
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (vp[4] && vp[3]) |=> out_valid); // R3
endmodule

bind booth_csa_mult booth_csa_mult_chk #(.MCAND_W(MCAND_W), .MPLIER_W(MPLIER_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mcand(mcand), .mplier(mplier),
  .out_valid(out_valid), .sum_vec(sum_vec), .carry_vec(carry_vec)
);

// File: tb/booth_csa_mult_tb.sv
module booth_csa_mult_tb;
  localparam int AW = 54;
  localparam int BW = 53;
  localparam int PW = AW + BW;
  localparam int NV = 8;

  localparam logic [AW-1:0] TA [NV] = '{
    54'h00_0000_0000_0001, 54'h3F_FFFF_FFFF_FFFF, 54'h2A_AAAA_AAAA_AAAA,
    54'h20_0000_0000_0000, 54'h12_3456_789A_BCDE, 54'h00_0000_0000_0000,
    54'h3F_0F0F_0F0F_0F0F, 54'h00_0000_0000_0003};
  localparam logic [BW-1:0] TB [NV] = '{
    53'h00_0000_0000_0001, 53'h1F_FFFF_FFFF_FFFF, 53'h15_5555_5555_5555,
    53'h10_0000_0000_0001, 53'h0F_EDCB_A987_6543, 53'h1F_FFFF_FFFF_FFFF,
    53'h1C_CCCC_CCCC_CCCC, 53'h00_0000_0000_0017};

  logic clk = 1'b0;
  logic rst, in_valid;
  logic [AW-1:0] mcand;
  logic [BW-1:0] mplier;
  logic out_valid;
  logic [PW-1:0] sum_vec, carry_vec;

  int checks = 0;
  int errors = 0;
  logic mon_on = 1'b0;
  logic hv [5];
  logic [PW-1:0] hp [5];

  always #2 clk = ~clk;

  booth_csa_mult #(.MCAND_W(AW), .MPLIER_W(BW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mcand(mcand), .mplier(mplier),
    .out_valid(out_valid), .sum_vec(sum_vec), .carry_vec(carry_vec));

  function automatic logic [PW-1:0] prod(logic [AW-1:0] a, logic [BW-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (out_valid !== hv[4]) begin
        errors++;
        $display("FAIL R2 R5 out_valid actual=%b expected=%b", out_valid, hv[4]);
      end
      if (hv[4] && out_valid === 1'b1) begin
        checks++;
        if (PW'(sum_vec + carry_vec) !== hp[4]) begin
          errors++;
          $display("FAIL R1 R3 product actual=%h expected=%h", PW'(sum_vec + carry_vec), hp[4]);
        end
      end
    end
    for (int k = 4; k > 0; k--) begin
      hv[k] = rst ? 1'b0 : hv[k-1];
      hp[k] = hp[k-1];
    end
    hv[0] = rst ? 1'b0 : in_valid;
    hp[0] = prod(mcand, mplier);
  end

  task automatic single(input logic [AW-1:0] a, input logic [BW-1:0] b, input string tag);
    logic [PW-1:0] exp_p;
    exp_p = prod(a, b);
    @(posedge clk); #1;
    in_valid = 1'b1; mcand = a; mplier = b;
    @(posedge clk); #1;
    in_valid = 1'b0; mcand = ~a; mplier = ~b;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b1 || PW'(sum_vec + carry_vec) !== exp_p) begin
      errors++;
      $display("FAIL %s valid=%b actual=%h expected=%h", tag, out_valid,
               PW'(sum_vec + carry_vec), exp_p);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 5; k++) begin hv[k] = 1'b0; hp[k] = '0; end
    rst = 1'b1; in_valid = 1'b0; mcand = '0; mplier = '0;
    repeat (3) @(posedge clk); #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R4 reset out_valid actual=%b expected=0", out_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    mon_on = 1'b1;

    // R1 R3 R5: back-to-back table stream with one bubble carrying junk data
    for (int i = 0; i < NV; i++) begin
      if (i == 4) begin
        @(posedge clk); #1;
        in_valid = 1'b0; mcand = 54'h15_5555_5555_5555; mplier = 53'h0A_AAAA_AAAA_AAAA;
      end
      @(posedge clk); #1;
      in_valid = 1'b1; mcand = TA[i]; mplier = TB[i];
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (8) @(posedge clk);

    single({AW{1'b1}}, {BW{1'b1}}, "R6 all-ones");
    single(54'h2D_1B3C_0F77_8E21, 53'h12_4924_9249_2492, "R7 minus-two digits");
    single(54'h3A_5A5A_C3C3_9669, 53'h1A_AAAA_AAAA_AAAB, "R7 minus-one digits");
    single('0, 53'h1B_CDEF_0123_4567, "R8 zero multiplicand");
    single(54'h00_0000_0000_0003, 53'h00_0000_0000_0017, "R1 small");

    // R4: reset in the middle of a stream flushes in-flight pairs
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; mcand = TA[i+1]; mplier = TB[i+1];
    end
    @(posedge clk); #1;
    in_valid = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0; in_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R4 flush out_valid actual=%b expected=0", out_valid);
      end
    end
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule